// File: doc/BRIEF.md
# UART Receive Line Status and Break Detection

This block keeps the line status flags of a 16550-style UART. The receiver hands it each finished character along with that character's parity and framing error flags. The block stores the character and its error tags together in a receive queue. An error becomes visible in the status byte only once its character reaches the head of the queue. A separate flag stays high while any tagged entry remains anywhere in the queue.

The block also watches the raw serial input for a break. A break is a line held low for longer than a whole character time. Each break puts exactly one all-zero entry, tagged as a break, into the queue. A new break can only be detected after the line has gone high again for a full bit time.

On the transmit side, the block turns the transmit FIFO and shift-register empty indications into two flags: holding-register-empty and transmitter-empty. It also raises a transmit-empty interrupt request when that interrupt is enabled. Status reads, queue pops and transmit writes arrive as single-cycle strobes.

Top module: `uart_status_core`

## Requirements
- R1: Bit 0 of `status_o` is 1 exactly while the receive queue holds at least one entry. `rx_head_o` shows the oldest entry's data. Entries leave in arrival order when `rx_pop_i` is high, and the queue holds DEPTH (16) entries. All flag changes appear one clock after the causing strobe.
- R2: Bit 2 (parity error) and bit 3 (framing error) show the tags of the head entry only. They are 0 while the queue is empty.
- R3: A status read (`status_rd_i`) with a non-empty queue hides the head entry's tag bits (2, 3, 4) until that entry is popped. The next head shows its own tags.
- R4: Bit 7 is 1 whenever at least one entry in the queue carries a parity, framing or break tag.
- R5: Once set, bit 7 stays 1 until a status read. The read clears it only if no tagged entry remains in the queue after that cycle.
- R6: When `rx_line_i` is sampled 0 on CHAR_BITS*BIT_CYCLES+1 consecutive clocks, one entry is pushed with data 0x00 and the break tag set. Bit 4 shows that tag while the entry is at the head.
- R7: A low period inserts at most one break entry. A further break needs `rx_line_i` sampled 1 on BIT_CYCLES consecutive clocks first. Out of reset the detector is armed.
- R8: Bit 6 resets to 1. One clock after any cycle, it equals that cycle's `tx_fifo_empty_i AND tx_shift_empty_i`.
- R9: Bit 5 resets to 1. A cycle with `tx_wr_i` high makes it 0 on the next clock. Otherwise a cycle with `tx_fifo_empty_i` high makes it 1, and it holds in any other cycle.
- R10: `thre_irq_o` is bit 5 AND `thre_ie_i`.
- R11: A character (or break) that arrives while the queue is full is discarded and sets bit 1 (overrun). A status read clears bit 1 unless a new overrun happens in the same cycle. A pop in the same cycle does not make room.
- R12: After reset `status_o` is 0x60 and `rx_head_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done_i | input | 1 | Receiver finished a character this cycle |
| rx_char_i | input | 8 | Received character data |
| rx_perr_i | input | 1 | Parity error flag for the character |
| rx_ferr_i | input | 1 | Framing error flag for the character |
| rx_line_i | input | 1 | Raw serial input level (synchronised) |
| rx_pop_i | input | 1 | Remove the head entry of the receive queue |
| tx_fifo_empty_i | input | 1 | Transmit FIFO is empty |
| tx_shift_empty_i | input | 1 | Transmit shift register is empty |
| tx_wr_i | input | 1 | A byte is written into the transmit FIFO |
| thre_ie_i | input | 1 | Transmit-empty interrupt enable |
| status_rd_i | input | 1 | Status byte is read this cycle |
| rx_head_o | output | 8 | Data of the head entry |
| status_o | output | 8 | Status flags (bit positions as in R1–R11) |
| thre_irq_o | output | 1 | Transmit-empty interrupt request |

## Verification
The bench fills the queue with every combination of parity and framing tags and then overfills it. A design that reported tags from the newest entry, or reused a full slot, would show wrong bits or wrong data as the queue drains. Status reads are interleaved with pops, which catches a summary flag that clears while tagged entries remain, or head tags that stay visible after a read. The bench holds the line low for exactly the threshold, for one clock more, and for a long stretch, with high gaps just short of and exactly one bit time. These runs expose an off-by-one threshold, repeated break entries, and re-arming too early. A sweep of all transmit strobe and enable combinations checks the one-clock latency and the write-over-empty priority of the transmit flags.

// File: rtl/uart_status_pkg.sv
package uart_status_pkg;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // status byte bit positions
    localparam int ST_DR   = 0;
    localparam int ST_OE   = 1;
    localparam int ST_PE   = 2;
    localparam int ST_FE   = 3;
    localparam int ST_BI   = 4;
    localparam int ST_THRE = 5;
    localparam int ST_TEMT = 6;
    localparam int ST_ERR  = 7;

    function automatic logic entry_bad(input rx_entry_t e);
        return e.brk | e.ferr | e.perr;
    endfunction
endpackage

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import uart_status_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t entry_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      empty_o,
    output logic      full_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        rx_entry_t [DEPTH-1:0] mem;
        logic [AW-1:0]         wr;
        logic [AW-1:0]         rd;
        logic [CW-1:0]         cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic push_ok, pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d     = s_q;
        push_ok = push_i && (s_q.cnt != CW'(DEPTH));
        pop_ok  = pop_i && (s_q.cnt != '0);
        if (push_ok) begin
            s_d.mem[s_q.wr] = entry_i;
            s_d.wr          = bump(s_q.wr);
        end
        if (pop_ok) begin
            s_d.rd = bump(s_q.rd);
        end
        s_d.cnt = s_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head_o  = s_q.mem[s_q.rd];
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CW'(DEPTH));
endmodule

// File: rtl/break_watch.sv
module break_watch #(
    parameter int BIT_CYCLES = 16,
    parameter int CHAR_BITS  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic brk_o
);
    localparam int CHAR_CYCLES = BIT_CYCLES * CHAR_BITS;
    localparam int LW = $clog2(CHAR_CYCLES + 1);
    localparam int HW = $clog2(BIT_CYCLES + 1);

    typedef struct packed {
        logic [LW-1:0] low_run;
        logic [HW-1:0] high_run;
        logic          armed;
    } watch_state_t;

    watch_state_t s_d, s_q;
    logic fire;

    always_comb begin
        s_d  = s_q;
        fire = s_q.armed && !line_i && (s_q.low_run == LW'(CHAR_CYCLES));
        if (line_i) begin
            s_d.low_run = '0;
            if (s_q.high_run != HW'(BIT_CYCLES)) s_d.high_run = s_q.high_run + 1'b1;
            if (s_d.high_run == HW'(BIT_CYCLES)) s_d.armed = 1'b1;
        end else begin
            s_d.high_run = '0;
            if (s_q.low_run != LW'(CHAR_CYCLES)) s_d.low_run = s_q.low_run + 1'b1;
            if (fire) s_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{low_run: '0, high_run: '0, armed: 1'b1};
        else        s_q <= s_d;
    end

    assign brk_o = fire;
endmodule

// File: rtl/tx_flag_track.sv
module tx_flag_track (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty_i,
    input  logic shift_empty_i,
    input  logic wr_i,
    input  logic ie_i,
    output logic thre_o,
    output logic temt_o,
    output logic irq_o
);
    typedef struct packed {
        logic thre;
        logic temt;
    } tx_state_t;

    tx_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.temt = fifo_empty_i && shift_empty_i;
        if (wr_i)              s_d.thre = 1'b0;
        else if (fifo_empty_i) s_d.thre = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{thre: 1'b1, temt: 1'b1};
        else        s_q <= s_d;
    end

    assign thre_o = s_q.thre;
    assign temt_o = s_q.temt;
    assign irq_o  = s_q.thre && ie_i;
endmodule

// File: rtl/uart_status_core.sv
module uart_status_core
    import uart_status_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int BIT_CYCLES = 16,
    parameter int CHAR_BITS  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_done_i,
    input  logic [DATA_W-1:0] rx_char_i,
    input  logic              rx_perr_i,
    input  logic              rx_ferr_i,
    input  logic              rx_line_i,
    input  logic              rx_pop_i,
    input  logic              tx_fifo_empty_i,
    input  logic              tx_shift_empty_i,
    input  logic              tx_wr_i,
    input  logic              thre_ie_i,
    input  logic              status_rd_i,
    output logic [DATA_W-1:0] rx_head_o,
    output logic [7:0]        status_o,
    output logic              thre_irq_o
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic          head_seen;
        logic [CW-1:0] err_cnt;
        logic          err_sum;
        logic          overrun;
    } core_state_t;

    core_state_t s_d, s_q;
    rx_entry_t   new_entry, head;
    logic        brk_evt, push, push_ok, pop_ok, fifo_empty, fifo_full;
    logic        thre, temt;

    break_watch #(.BIT_CYCLES(BIT_CYCLES), .CHAR_BITS(CHAR_BITS)) u_brk (
        .clk(clk), .rst_n(rst_n), .line_i(rx_line_i), .brk_o(brk_evt)
    );

    rx_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .entry_i(new_entry),
        .pop_i(rx_pop_i), .head_o(head), .empty_o(fifo_empty), .full_o(fifo_full)
    );

    tx_flag_track u_tx (
        .clk(clk), .rst_n(rst_n), .fifo_empty_i(tx_fifo_empty_i),
        .shift_empty_i(tx_shift_empty_i), .wr_i(tx_wr_i), .ie_i(thre_ie_i),
        .thre_o(thre), .temt_o(temt), .irq_o(thre_irq_o)
    );

    always_comb begin
        s_d = s_q;
        // a break takes the slot; it is never merged with a character
        if (brk_evt) new_entry = '{brk: 1'b1, ferr: 1'b0, perr: 1'b0, data: '0};
        else         new_entry = '{brk: 1'b0, ferr: rx_ferr_i, perr: rx_perr_i, data: rx_char_i};
        push    = brk_evt || rx_done_i;
        push_ok = push && !fifo_full;
        pop_ok  = rx_pop_i && !fifo_empty;

        s_d.err_cnt = s_q.err_cnt + CW'(push_ok && entry_bad(new_entry))
                                  - CW'(pop_ok && entry_bad(head));
        s_d.err_sum = (s_d.err_cnt != '0) || (s_q.err_sum && !status_rd_i);
        s_d.overrun = (push && fifo_full) || (s_q.overrun && !status_rd_i);

        if (pop_ok)                         s_d.head_seen = 1'b0;
        else if (status_rd_i && !fifo_empty) s_d.head_seen = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    logic show_tags;
    assign show_tags = !fifo_empty && !s_q.head_seen;

    always_comb begin
        status_o          = '0;
        status_o[ST_DR]   = !fifo_empty;
        status_o[ST_OE]   = s_q.overrun;
        status_o[ST_PE]   = show_tags && head.perr;
        status_o[ST_FE]   = show_tags && head.ferr;
        status_o[ST_BI]   = show_tags && head.brk;
        status_o[ST_THRE] = thre;
        status_o[ST_TEMT] = temt;
        status_o[ST_ERR]  = s_q.err_sum;
    end

    assign rx_head_o = head.data;
endmodule

// File: rtl/uart_status_chk.sv
module uart_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_done_i,
    input logic       rx_line_i,
    input logic       tx_fifo_empty_i,
    input logic       tx_shift_empty_i,
    input logic       tx_wr_i,
    input logic       status_rd_i,
    input logic [7:0] status_o,
    input logic       thre_irq_o
);
    assert_tags_imply_summary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|status_o[4:2]) |-> status_o[7]);

    assert_no_tags_when_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[0] |-> (status_o[4:2] == 3'b000));

    assert_write_clears_thre_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_wr_i |=> !status_o[5]);

    assert_temt_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_fifo_empty_i && tx_shift_empty_i) |=> status_o[6]);

    assert_temt_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_fifo_empty_i |=> !status_o[6]);

    assert_irq_needs_thre_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !status_o[5] |-> !thre_irq_o);

    assert_read_clears_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd_i && !rx_done_i && rx_line_i) |=> !status_o[1]);
endmodule

bind uart_status_core uart_status_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done_i), .rx_line_i(rx_line_i),
    .tx_fifo_empty_i(tx_fifo_empty_i), .tx_shift_empty_i(tx_shift_empty_i),
    .tx_wr_i(tx_wr_i), .status_rd_i(status_rd_i), .status_o(status_o),
    .thre_irq_o(thre_irq_o)
);

// File: tb/uart_status_core_test.sv
`timescale 1ns/1ps
module uart_status_core_test;
    localparam int DEPTH = 16;
    localparam int BC    = 2;
    localparam int CB    = 4;
    localparam int CC    = BC * CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_done = 0, rx_perr = 0, rx_ferr = 0, rx_line = 1, rx_pop = 0;
    logic [7:0] rx_char = 0;
    logic txe = 1, shift_e = 1, tx_wr = 0, ie = 0, rd = 0;
    logic [7:0] head, status;
    logic irq;

    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    uart_status_core #(.DEPTH(DEPTH), .BIT_CYCLES(BC), .CHAR_BITS(CB)) uut (
        .clk(clk), .rst_n(rst_n), .rx_done_i(rx_done), .rx_char_i(rx_char),
        .rx_perr_i(rx_perr), .rx_ferr_i(rx_ferr), .rx_line_i(rx_line),
        .rx_pop_i(rx_pop), .tx_fifo_empty_i(txe), .tx_shift_empty_i(shift_e),
        .tx_wr_i(tx_wr), .thre_ie_i(ie), .status_rd_i(rd),
        .rx_head_o(head), .status_o(status), .thre_irq_o(irq)
    );

    // reference model, entries are {brk, ferr, perr, data}
    logic [10:0] mq[$];
    logic m_seen = 0, m_esum = 0, m_ovr = 0, m_thre = 1, m_temt = 1, m_armed = 1;
    int   m_low = 0, m_high = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        logic brk_evt, push, full, empty, pop_ok, push_ok, any_err;
        logic [10:0] ent;
        brk_evt = m_armed && !rx_line && (m_low == CC);
        push    = brk_evt || rx_done;
        ent     = brk_evt ? 11'h400 : {1'b0, rx_ferr, rx_perr, rx_char};
        full    = (mq.size() == DEPTH);
        empty   = (mq.size() == 0);
        pop_ok  = rx_pop && !empty;
        push_ok = push && !full;
        if (pop_ok) m_seen = 0;
        else if (rd && !empty) m_seen = 1;
        m_ovr = (push && full) || (m_ovr && !rd);
        if (pop_ok) void'(mq.pop_front());
        if (push_ok) mq.push_back(ent);
        any_err = 0;
        foreach (mq[i]) if (mq[i][10:8] != 3'b000) any_err = 1;
        m_esum = any_err || (m_esum && !rd);
        if (tx_wr) m_thre = 0;
        else if (txe) m_thre = 1;
        m_temt = txe && shift_e;
        if (rx_line) begin
            m_low = 0;
            if (m_high != BC) m_high++;
            if (m_high == BC) m_armed = 1;
        end else begin
            m_high = 0;
            if (m_low != CC) m_low++;
            if (brk_evt) m_armed = 0;
        end
    endtask

    task automatic compare();
        logic [2:0] tags;
        logic ne;
        ne   = (mq.size() != 0);
        tags = (ne && !m_seen) ? mq[0][10:8] : 3'b000;
        chk("R1 data-ready", status[0], ne);
        chk("R11 overrun", status[1], m_ovr);
        chk("R2 parity", status[2], tags[0]);
        chk("R2 framing", status[3], tags[1]);
        chk("R6 break bit", status[4], tags[2]);
        chk("R9 thre", status[5], m_thre);
        chk("R8 temt", status[6], m_temt);
        chk("R4 summary", status[7], m_esum);
        chk("R10 irq", irq, m_thre && ie);
        if (ne) chk("R1 head data", head, mq[0][7:0]);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
        rx_done = 0; rx_pop = 0; tx_wr = 0; rd = 0;
    endtask

    task automatic push_char(input logic [7:0] d, input logic pe, input logic fe);
        rx_done = 1; rx_char = d; rx_perr = pe; rx_ferr = fe;
        tick();
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: all requirements, got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R12 reset status", status, 8'h60);
        chk("R12 reset head", head, 8'h00);
        chk("R10 reset irq", irq, 1'b0);

        // R1 R2 fill with every tag combination, then overfill
        for (int d = 0; d < DEPTH; d++)
            push_char(8'(d * 37 + 5), d[0], d[1]);
        push_char(8'hEE, 1'b1, 1'b1);
        chk("R11 overrun set", status[1], 1'b1);
        rx_pop = 1; rx_done = 1; rx_char = 8'h11; rx_perr = 0; rx_ferr = 0;
        tick();
        chk("R11 pop does not make room", status[1], 1'b1);
        rd = 1; tick();
        chk("R11 read clears", status[1], 1'b0);
        chk("R5 read keeps summary while tags remain", status[7], 1'b1);
        // drain with read before each pop
        for (int k = 0; k < DEPTH; k++) begin
            rd = 1; tick();
            chk("R3 tags hidden after read", status[4:2], 3'b000);
            rx_pop = 1; tick();
        end
        rd = 1; tick();
        chk("R5 read clears summary when none remain", status[7], 1'b0);

        // R1 simultaneous push and pop, varied patterns
        push_char(8'hA5, 1'b0, 1'b0);
        for (int k = 0; k < 12; k++) begin
            rx_pop = 1; rx_done = 1; rx_char = 8'(k * 29); rx_perr = k[1]; rx_ferr = k[2];
            tick();
        end
        rx_pop = 1; tick();
        chk("R1 queue empty", status[0], 1'b0);
        rd = 1; tick();

        // R4 R5 summary with a tagged entry popped before a read
        push_char(8'h01, 1'b1, 1'b0);
        push_char(8'h02, 1'b0, 1'b0);
        rx_pop = 1; tick();
        chk("R5 summary sticky until read", status[7], 1'b1);
        rd = 1; tick();
        chk("R5 cleared with clean queue", status[7], 1'b0);
        rx_pop = 1; tick();

        // R8 R9 R10 transmit sweep
        for (int r = 0; r < 2; r++)
            for (int v = 0; v < 16; v++) begin
                txe = v[0]; shift_e = v[1]; tx_wr = v[2]; ie = v[3];
                tick();
            end
        txe = 1; shift_e = 1; ie = 0; tick();

        // R6 R7 break detection
        rx_line = 0;
        for (int k = 0; k < CC; k++) tick();
        chk("R6 no break at threshold", status[0], 1'b0);
        tick();
        chk("R6 break entry", status[4:0], 5'b10001);
        chk("R6 break data zero", head, 8'h00);
        for (int k = 0; k < 30; k++) tick();
        rx_pop = 1; tick();
        chk("R7 single entry per low period", status[0], 1'b0);
        rx_line = 1;
        for (int k = 0; k < BC - 1; k++) tick();
        rx_line = 0;
        for (int k = 0; k < CC + 3; k++) tick();
        chk("R7 short high does not rearm", status[0], 1'b0);
        rx_line = 1;
        for (int k = 0; k < BC; k++) tick();
        rx_line = 0;
        for (int k = 0; k < CC + 1; k++) tick();
        chk("R7 rearmed after bit time", status[0], 1'b1);
        rx_line = 1;
        rd = 1; tick();
        chk("R3 break bit hidden after read", status[4], 1'b0);
        rx_pop = 1; tick();
        rd = 1; tick();
        chk("R5 summary clear after break drained", status[7], 1'b0);

        summary();
        $finish;
    end
endmodule